// File: doc/BRIEF.md
# Isochronous Descriptor Ring Fetcher

This block walks a circular list of transfer descriptors on behalf of a device-side isochronous endpoint. The descriptors live in a small on-chip memory that software fills through a write port and can read back through a registered read port. Running ahead of consumption, the block copies upcoming descriptors into a small prefetch cache. It consumes exactly one descriptor for each service interval that the token source offers. A descriptor that hardware owns is turned into a data request toward the data mover. Once the mover reports completion, the block writes a status word back into memory. A descriptor that software has not handed over costs the interval and produces a missed-interval event, and the ring moves on.

The cache is not coherent with the memory. A descriptor that software re-arms after the block has already cached it stays invisible until software issues an update command. That command drops the cache and refetches from the next unconsumed position, and any transfer already under way carries on. A link descriptor redirects the fetch pointer, which is how the ring closes on itself. Events leave through a valid/ready queue. The block stops taking intervals rather than lose an event.

Top module: `isoc_ring_fetcher`

## Requirements
- R1: A descriptor word is 16 bits: bit 15 hardware-owned, bit 14 interrupt-on-complete, bit 13 link, bit 12 done, bits 11:0 length (for a link descriptor, bits 3:0 of this field hold the target index). Write-back after a transfer stores owned=0, link=0, done=1, the original interrupt-on-complete bit and the count reported by the data mover.
- R2: A start command clears the cache, loads the fetch pointer with the given base and begins running. Intervals then consume descriptors in ring order, one per accepted interval.
- R3: When the fetcher reads a link descriptor, it does not cache it and continues fetching at the target index.
- R4: An accepted interval whose cached head descriptor is owned raises mv_req with mv_len equal to the descriptor length. Both are held until mv_done, and the write-back of R1 lands in the same cycle as mv_done.
- R5: A completed descriptor whose interrupt-on-complete bit is set produces an event of kind 1 carrying its index. A completed descriptor without that bit produces no event.
- R6: An interval accepted while the block is not running produces an event of kind 2 with index 0 and no data request.
- R7: An interval accepted while the cached head descriptor is not owned produces an event of kind 3 with that descriptor's index, and no data request. The ring advances past that descriptor.
- R8: A descriptor re-armed in memory after it was cached keeps its cached (stale) contents, and it is consumed with those contents.
- R9: An update command flushes the cache and refetches from the next unconsumed descriptor. An active data request keeps its request and length through the update.
- R10: A stop command halts fetching and clears the cache. Later intervals produce kind-2 events.
- R11: An event presented with ev_ready low keeps its kind and index until taken. itv_ready is low while a transfer is active, while the event queue is full, while a command is being given, or while running with an empty cache.
- R12: Out of reset, ev_valid and mv_req are low, itv_ready is high, and memory reads as zero.
- R13: sw_rdata shows the memory word at sw_addr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_base | input | 4 | Ring base index for start |
| cmd_update | input | 1 | Update (flush and refetch) command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| sw_we | input | 1 | Software descriptor write enable |
| sw_addr | input | 4 | Software descriptor address |
| sw_wdata | input | 16 | Software descriptor write data |
| sw_rdata | output | 16 | Software descriptor read data, one cycle latency |
| itv_valid | input | 1 | Service interval offered |
| itv_ready | output | 1 | Interval can be accepted |
| mv_req | output | 1 | Data movement requested |
| mv_len | output | 12 | Requested length |
| mv_done | input | 1 | Data movement complete |
| mv_count | input | 12 | Length actually moved |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Event consumer ready |
| ev_kind | output | 2 | Event kind: 1 progress, 2 not-ready, 3 missed |
| ev_idx | output | 4 | Descriptor index of the event |

## Verification
The assertions watch, on every cycle, that events are never pushed into a full queue and stay stable under backpressure, that a data request and its length hold until done, that no interval is taken while a transfer is active, that the cache never exceeds its capacity, and that progress events follow a completion. Only the bench scenarios can show the ring semantics: the order of consumption, the link wrap, the exact write-back words, and the stale cached descriptor that becomes visible only after an update. They also cover the not-ready behaviour before start and after stop.

// File: rtl/isoc_ring_pkg.sv
package isoc_ring_pkg;

  localparam int LEN_W = 12;

  typedef struct packed {
    logic             own;
    logic             ioc;
    logic             link;
    logic             done;
    logic [LEN_W-1:0] len;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [1:0] {
    EV_NONE      = 2'd0,
    EV_PROGRESS  = 2'd1,
    EV_NOT_READY = 2'd2,
    EV_MISSED    = 2'd3
  } ev_kind_t;

  // Status word stored after a transfer finishes.
  function automatic desc_t retire_desc(input desc_t d, input logic [LEN_W-1:0] moved);
    desc_t r;
    r      = '0;
    r.ioc  = d.ioc;
    r.done = 1'b1;
    r.len  = moved;
    return r;
  endfunction

endpackage

// File: rtl/isoc_desc_mem.sv
module isoc_desc_mem
  import isoc_ring_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  desc_t         sw_wdata,
  output desc_t         sw_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  desc_t         eng_wdata,
  input  logic [AW-1:0] eng_raddr,
  output desc_t         eng_rdata
);

  desc_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      sw_rdata <= '0;
    end else begin
      if (eng_we) mem_q[eng_waddr] <= eng_wdata;
      if (sw_we)  mem_q[sw_addr]   <= sw_wdata;
      sw_rdata <= mem_q[sw_addr];
    end
  end

  assign eng_rdata = mem_q[eng_raddr];

endmodule

// File: rtl/isoc_desc_cache.sv
module isoc_desc_cache
  import isoc_ring_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  desc_t         push_d,
  input  logic [AW-1:0] push_idx,
  input  logic          pop,
  output desc_t         head_d,
  output logic [AW-1:0] head_idx,
  output logic [CW-1:0] count,
  output logic          full
);

  desc_t         d_q [N];
  logic [AW-1:0] i_q [N];
  logic [PW-1:0] hd_q, tl_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  logic do_push, do_pop;
  assign do_push = push && (cnt_q != CW'(N));
  assign do_pop  = pop && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) tl_q <= step(tl_q);
      if (do_pop)  hd_q <= step(hd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) begin
      d_q[tl_q] <= push_d;
      i_q[tl_q] <= push_idx;
    end
  end

  assign head_d   = d_q[hd_q];
  assign head_idx = i_q[hd_q];
  assign count    = cnt_q;
  assign full     = (cnt_q == CW'(N));

endmodule

// File: rtl/isoc_ev_queue.sv
module isoc_ev_queue #(
  parameter int N  = 4,
  parameter int AW = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [1:0]    push_kind,
  input  logic [AW-1:0] push_idx,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic [AW-1:0] out_idx,
  output logic          full
);

  logic [1:0]    k_q [N];
  logic [AW-1:0] i_q [N];
  logic [PW-1:0] hd_q, tl_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  logic do_push, do_pop;
  assign do_push = push && (cnt_q != CW'(N));
  assign do_pop  = out_ready && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) tl_q <= step(tl_q);
      if (do_pop)  hd_q <= step(hd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      k_q[tl_q] <= push_kind;
      i_q[tl_q] <= push_idx;
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_kind  = k_q[hd_q];
  assign out_idx   = i_q[hd_q];
  assign full      = (cnt_q == CW'(N));

endmodule

// File: rtl/isoc_ring_fetcher.sv
module isoc_ring_fetcher
  import isoc_ring_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int CACHE_N = 4,
  parameter int EQ_N    = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(CACHE_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [AW-1:0]     cmd_base,
  input  logic              cmd_update,
  input  logic              cmd_stop,
  input  logic              sw_we,
  input  logic [AW-1:0]     sw_addr,
  input  logic [DESC_W-1:0] sw_wdata,
  output logic [DESC_W-1:0] sw_rdata,
  input  logic              itv_valid,
  output logic              itv_ready,
  output logic              mv_req,
  output logic [LEN_W-1:0]  mv_len,
  input  logic              mv_done,
  input  logic [LEN_W-1:0]  mv_count,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [1:0]        ev_kind,
  output logic [AW-1:0]     ev_idx
);

  // ring index arithmetic
  function automatic logic [AW-1:0] ring_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] link_target(input desc_t d);
    return d.len[AW-1:0];
  endfunction

  // state
  logic             running;
  logic [AW-1:0]    fptr;
  logic             act;
  logic [AW-1:0]    act_idx;
  logic             act_ioc;
  logic [LEN_W-1:0] act_len;

  // named internal events
  logic          flush;
  logic          accept;
  logic          fetch_fire;
  logic          fetch_link;
  logic          wb_fire;
  logic          ev_push;
  logic [1:0]    ev_push_kind;
  logic [AW-1:0] ev_push_idx;
  logic [AW-1:0] resume_pos;

  // sub-block wires
  desc_t         fetch_d, sw_rd_d, head_d, wb_d;
  logic [AW-1:0] head_idx;
  logic [CW-1:0] cache_cnt;
  logic          cache_full;
  logic          eq_full;
  logic          cache_push, cache_pop;

  isoc_desc_mem #(.DEPTH(DEPTH)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (sw_we),
    .sw_addr   (sw_addr),
    .sw_wdata  (desc_t'(sw_wdata)),
    .sw_rdata  (sw_rd_d),
    .eng_we    (wb_fire),
    .eng_waddr (act_idx),
    .eng_wdata (wb_d),
    .eng_raddr (fptr),
    .eng_rdata (fetch_d)
  );
  assign sw_rdata = sw_rd_d;

  isoc_desc_cache #(.N(CACHE_N), .AW(AW)) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push     (cache_push),
    .push_d   (fetch_d),
    .push_idx (fptr),
    .pop      (cache_pop),
    .head_d   (head_d),
    .head_idx (head_idx),
    .count    (cache_cnt),
    .full     (cache_full)
  );

  isoc_ev_queue #(.N(EQ_N), .AW(AW)) u_evq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_push),
    .push_kind (ev_push_kind),
    .push_idx  (ev_push_idx),
    .out_valid (ev_valid),
    .out_ready (ev_ready),
    .out_kind  (ev_kind),
    .out_idx   (ev_idx),
    .full      (eq_full)
  );

  // command and interval decode
  assign flush      = cmd_start || cmd_stop || cmd_update;
  assign itv_ready  = !act && !eq_full && !flush && (!running || (cache_cnt != '0));
  assign accept     = itv_valid && itv_ready;
  assign cache_pop  = accept && running;
  assign resume_pos = (cache_cnt != '0) ? head_idx : fptr;

  // prefetch
  assign fetch_fire = running && !flush && !cache_full;
  assign fetch_link = fetch_fire && fetch_d.link;
  assign cache_push = fetch_fire && !fetch_d.link;

  // completion
  assign wb_fire = act && mv_done;
  assign wb_d    = retire_desc(desc_t'({1'b0, act_ioc, 2'b00, act_len}), mv_count);

  // event source selection: intervals and completions never coincide
  always_comb begin
    ev_push      = 1'b0;
    ev_push_kind = EV_NONE;
    ev_push_idx  = '0;
    if (accept && !running) begin
      ev_push      = 1'b1;
      ev_push_kind = EV_NOT_READY;
    end else if (accept && !head_d.own) begin
      ev_push      = 1'b1;
      ev_push_kind = EV_MISSED;
      ev_push_idx  = head_idx;
    end else if (wb_fire && act_ioc) begin
      ev_push      = 1'b1;
      ev_push_kind = EV_PROGRESS;
      ev_push_idx  = act_idx;
    end
  end

  // fetch pointer and run state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      fptr    <= '0;
    end else if (cmd_start) begin
      running <= 1'b1;
      fptr    <= cmd_base;
    end else if (cmd_stop) begin
      running <= 1'b0;
    end else if (cmd_update) begin
      fptr <= resume_pos;
    end else if (fetch_fire) begin
      fptr <= fetch_link ? link_target(fetch_d) : ring_step(fptr);
    end
  end

  // active transfer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= 1'b0;
      act_idx <= '0;
      act_ioc <= 1'b0;
      act_len <= '0;
    end else if (cache_pop && head_d.own) begin
      act     <= 1'b1;
      act_idx <= head_idx;
      act_ioc <= head_d.ioc;
      act_len <= head_d.len;
    end else if (wb_fire) begin
      act <= 1'b0;
    end
  end

  assign mv_req = act;
  assign mv_len = act_len;

endmodule

// File: rtl/isoc_ring_fetcher_chk.sv
module isoc_ring_fetcher_chk
  import isoc_ring_pkg::*;
#(
  parameter int AW      = 4,
  parameter int CACHE_N = 4,
  localparam int CW = $clog2(CACHE_N + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             running,
  input logic             accept,
  input logic             fetch_fire,
  input logic             mv_req,
  input logic             mv_done,
  input logic [LEN_W-1:0] mv_len,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [1:0]       ev_kind,
  input logic [AW-1:0]    ev_idx,
  input logic             ev_push,
  input logic [1:0]       ev_push_kind,
  input logic             eq_full,
  input logic [CW-1:0]    cache_cnt
);

  p_ev_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_kind) && $stable(ev_idx));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |-> !eq_full);

  p_idle_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !mv_req);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req && !mv_done |=> mv_req && $stable(mv_len));

  p_cache_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cache_cnt <= CW'(CACHE_N));

  p_fetch_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |-> cache_cnt < CW'(CACHE_N));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> cache_cnt == '0);

  p_not_ready_dry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !running |=> !mv_req);

  p_progress_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push && ev_push_kind == EV_PROGRESS |-> mv_req && mv_done);

endmodule

bind isoc_ring_fetcher isoc_ring_fetcher_chk #(.AW(AW), .CACHE_N(CACHE_N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_start    (cmd_start),
  .running      (running),
  .accept       (accept),
  .fetch_fire   (fetch_fire),
  .mv_req       (mv_req),
  .mv_done      (mv_done),
  .mv_len       (mv_len),
  .ev_valid     (ev_valid),
  .ev_ready     (ev_ready),
  .ev_kind      (ev_kind),
  .ev_idx       (ev_idx),
  .ev_push      (ev_push),
  .ev_push_kind (ev_push_kind),
  .eq_full      (eq_full),
  .cache_cnt    (cache_cnt)
);

// File: tb/isoc_ring_fetcher_test.sv
module isoc_ring_fetcher_test;

  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_update = 1'b0, cmd_stop = 1'b0;
  logic [3:0]  cmd_base = '0;
  logic        sw_we = 1'b0;
  logic [3:0]  sw_addr = '0;
  logic [15:0] sw_wdata = '0;
  logic [15:0] sw_rdata;
  logic        itv_valid = 1'b0, itv_ready;
  logic        mv_req, mv_done = 1'b0;
  logic [11:0] mv_len, mv_count = '0;
  logic        ev_valid, ev_ready = 1'b1;
  logic [1:0]  ev_kind;
  logic [3:0]  ev_idx;

  always #2 clk = ~clk;

  isoc_ring_fetcher uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_base(cmd_base),
    .cmd_update(cmd_update), .cmd_stop(cmd_stop), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .itv_valid(itv_valid), .itv_ready(itv_ready),
    .mv_req(mv_req), .mv_len(mv_len), .mv_done(mv_done), .mv_count(mv_count),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_idx(ev_idx)
  );

  int checks = 0;
  int errors = 0;

  // event log
  int         ev_n = 0;
  logic [1:0] ev_k_log [64];
  logic [3:0] ev_i_log [64];
  always @(posedge clk) begin
    if (rst_n && ev_valid && ev_ready && ev_n < 64) begin
      ev_k_log[ev_n] <= ev_kind;
      ev_i_log[ev_n] <= ev_idx;
      ev_n <= ev_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit own, input bit ioc, input bit lnk, input int len);
    return {own, ioc, lnk, 1'b0, 12'(len)};
  endfunction

  function automatic logic [15:0] retired(input bit ioc, input int cnt);
    return {1'b0, ioc, 1'b0, 1'b1, 12'(cnt)};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write(input int a, input logic [15:0] d);
    sw_we = 1'b1; sw_addr = 4'(a); sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_read(input int a, output logic [15:0] d);
    sw_addr = 4'(a);
    @(negedge clk);
    d = sw_rdata;
  endtask

  task automatic pulse_start(input int base);
    cmd_start = 1'b1; cmd_base = 4'(base);
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic pulse_update();
    cmd_update = 1'b1;
    @(negedge clk);
    cmd_update = 1'b0;
  endtask

  task automatic pulse_stop();
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
  endtask

  task automatic interval();
    int w;
    w = 0;
    while (!itv_ready && w < 60) begin
      @(negedge clk);
      w++;
    end
    if (!itv_ready) begin
      checks++; errors++;
      $display("FAIL R11 itv_ready stuck low actual=0 expected=1");
    end else begin
      itv_valid = 1'b1;
      @(negedge clk);
      itv_valid = 1'b0;
    end
  endtask

  task automatic finish_xfer(input int cnt);
    mv_count = 12'(cnt); mv_done = 1'b1;
    @(negedge clk);
    mv_done = 1'b0;
  endtask

  task automatic expect_event(input string req, input int at, input int kind, input int idx);
    chk(req, "event kind", int'(ev_k_log[at]), kind);
    chk(req, "event index", int'(ev_i_log[at]), idx);
  endtask

  // kind: 0 transfer without event, 1 transfer with progress event, 3 missed
  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  idx;
    logic [11:0] len;
    logic [11:0] cnt;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'd1, 4'd2, 12'd10, 12'd9},
    '{2'd0, 4'd3, 12'd20, 12'd20},
    '{2'd1, 4'd4, 12'd30, 12'd1},
    '{2'd3, 4'd5, 12'd0,  12'd0},
    '{2'd1, 4'd6, 12'd40, 12'd40},
    '{2'd0, 4'd7, 12'd50, 12'd50},
    '{2'd3, 4'd2, 12'd0,  12'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int base_n;

    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12", "ev_valid after reset", ev_valid, 0);
    chk("R12", "mv_req after reset", mv_req, 0);
    chk("R12", "itv_ready after reset", itv_ready, 1);
    sw_read(9, rd);
    chk("R12", "memory word after reset", rd, 0);

    // R6 interval before any start
    base_n = ev_n;
    interval();
    chk("R6", "no data request", mv_req, 0);
    cyc(3);
    chk("R6", "one event", ev_n, base_n + 1);
    expect_event("R6", base_n, 2, 0);

    // ring at base 2, link at 8 back to 2, index 5 left to software
    sw_write(2, mk(1, 1, 0, 10));
    sw_write(3, mk(1, 0, 0, 20));
    sw_write(4, mk(1, 1, 0, 30));
    sw_write(5, mk(0, 1, 0, 99));
    sw_write(6, mk(1, 1, 0, 40));
    sw_write(7, mk(1, 0, 0, 50));
    sw_write(8, mk(0, 0, 1, 2));
    pulse_start(2);

    // R2 R4 R5 R7 R1 table walk, last entry wraps through the link (R3)
    for (int v = 0; v < 7; v++) begin
      base_n = ev_n;
      interval();
      if (VEC[v].kind != 2'd3) begin
        chk("R4", "mv_req raised", mv_req, 1);
        chk("R2", "consumed length in ring order", mv_len, VEC[v].len);
        cyc(2);
        chk("R4", "mv_len held until done", mv_len, VEC[v].len);
        finish_xfer(VEC[v].cnt);
        cyc(3);
        chk("R4", "mv_req dropped after done", mv_req, 0);
        sw_read(VEC[v].idx, rd);
        chk("R1", "write-back word", rd, retired(VEC[v].kind == 2'd1, VEC[v].cnt));
        if (VEC[v].kind == 2'd1) begin
          chk("R5", "progress event emitted", ev_n, base_n + 1);
          expect_event("R5", base_n, 1, VEC[v].idx);
        end else begin
          chk("R5", "no event without ioc", ev_n, base_n);
        end
      end else begin
        chk("R7", "no data on missed interval", mv_req, 0);
        cyc(3);
        chk("R7", "missed event emitted", ev_n, base_n + 1);
        expect_event(v == 6 ? "R3" : "R7", base_n, 3, VEC[v].idx);
      end
    end

    // R8 stale cache: re-arm index 3 after it was cached
    cyc(10);
    sw_write(3, mk(1, 1, 0, 60));
    sw_read(3, rd);
    chk("R13", "read back re-armed word", rd, mk(1, 1, 0, 60));
    base_n = ev_n;
    interval();
    chk("R8", "stale copy gives no request", mv_req, 0);
    cyc(3);
    expect_event("R8", base_n, 3, 3);

    // R9 update makes a re-armed descriptor visible
    cyc(6);
    sw_write(4, mk(1, 1, 0, 70));
    pulse_update();
    base_n = ev_n;
    interval();
    chk("R9", "refetched descriptor requested", mv_req, 1);
    chk("R9", "refetched length", mv_len, 70);
    pulse_update();
    cyc(1);
    chk("R9", "active request survives update", mv_req, 1);
    chk("R9", "active length survives update", mv_len, 70);
    finish_xfer(66);
    cyc(3);
    expect_event("R9", base_n, 1, 4);

    // R11 backpressure: four missed intervals fill the queue
    ev_ready = 1'b0;
    base_n = ev_n;
    for (int k = 0; k < 4; k++) interval();
    cyc(2);
    chk("R11", "itv_ready low when queue full", itv_ready, 0);
    chk("R11", "ev_valid held", ev_valid, 1);
    chk("R11", "held kind", ev_kind, 3);
    chk("R11", "held index", ev_idx, 5);
    cyc(3);
    chk("R11", "index still held", ev_idx, 5);
    ev_ready = 1'b1;
    cyc(6);
    chk("R11", "all queued events delivered", ev_n, base_n + 4);
    expect_event("R11", base_n,     3, 5);
    expect_event("R11", base_n + 1, 3, 6);
    expect_event("R11", base_n + 2, 3, 7);
    expect_event("R3",  base_n + 3, 3, 2);

    // R10 stop
    pulse_stop();
    base_n = ev_n;
    interval();
    chk("R10", "no request after stop", mv_req, 0);
    cyc(3);
    expect_event("R10", base_n, 2, 0);

    // R2 start at a new base
    sw_write(10, mk(1, 0, 0, 5));
    sw_write(11, mk(1, 1, 0, 6));
    sw_write(12, mk(0, 0, 1, 10));
    pulse_start(10);
    interval();
    chk("R2", "new base first length", mv_len, 5);
    finish_xfer(5);
    base_n = ev_n;
    interval();
    chk("R2", "new base second length", mv_len, 6);
    finish_xfer(6);
    cyc(3);
    expect_event("R5", base_n, 1, 11);

    cyc(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule